// File: doc/BRIEF.md
# Buck PWM/Hysteretic Mode Controller

This block is the digital mode supervisor for one synchronous buck phase. Each rising edge of `clk` is one oscillator (switching) cycle. The block decides whether the phase runs in fixed-frequency PWM or in pulse-skipping hysteretic operation. It turns that decision into high-side and low-side gate requests with a break-before-make interlock. It also releases the power-good enable and inhibits the PWM error path while in hysteretic operation. The analog parts (comparators, error amplifier, soft-start current source, dead-time circuits) sit outside the block and reach it as one-bit flags.

The controller holds in an idle state until it is enabled and the supply-undervoltage flag reports a good supply. It then runs a soft-start phase locked to PWM. Once the soft-start comparator reports its final level, power-good is released and mode changes become legal. The switch-node polarity flag holds the sample taken at the end of low-side conduction; it is read once per cycle. Eight positive samples in a row move the phase to hysteretic operation, and eight negative samples in a row move it back. A sharp load step that pulls the output under the PWM-return threshold forces PWM at once. Every change of mode passes through a one-cycle transition state in which both switches are off.

The states are ST_OFF (idle), ST_SOFTSTART (soft-start), ST_PWM, ST_TO_HYST (transition toward hysteretic), ST_HYST and ST_TO_PWM (transition toward PWM). The transitions are:
- any state to ST_OFF when `en` or `uvlo_ok` is low;
- ST_OFF to ST_SOFTSTART;
- ST_SOFTSTART to ST_PWM on `ss_done`;
- ST_PWM to ST_TO_HYST when the positive-run filter completes;
- ST_TO_HYST to ST_HYST;
- ST_HYST to ST_TO_PWM on `vout_drop` or when the negative-run filter completes;
- ST_TO_PWM to ST_PWM.

Top module: `buck_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and in every cycle after a clock edge that sampled `en` or `uvlo_ok` low, all of `hs_on`, `ls_on`, `mode_hyst`, `pgood_en` and `pwm_inhibit` are 0.
- R2: A clock edge that samples `en` and `uvlo_ok` both high while idle starts soft-start. After that edge the gates follow the PWM rule of R12, `mode_hyst` is 0 and `pgood_en` is 0.
- R3: During soft-start `mode_hyst` stays 0 whatever `sw_pos` does. `pgood_en` rises only on the edge after which the controller leaves soft-start, and that edge must have sampled `ss_done` = 1.
- R4: In PWM, the eighth consecutive edge that samples `sw_pos` = 1 starts the transition, and `mode_hyst` rises one edge later. An edge that samples `sw_pos` = 0 restarts the run.
- R5: In hysteretic mode, the eighth consecutive edge that samples `sw_pos` = 0 drops `mode_hyst` on that same edge. An edge that samples `sw_pos` = 1 restarts the run.
- R6: In hysteretic mode, an edge that samples `vout_drop` = 1 clears `mode_hyst` on that edge, without waiting for any run.
- R7: In the cycle between two modes (ST_TO_HYST or ST_TO_PWM), `hs_on` and `ls_on` are both 0.
- R8: `pwm_inhibit` is 1 exactly while `mode_hyst` is 1.
- R9: In hysteretic mode, an edge that samples `vout_lo` = 1 turns `hs_on` on at that edge if the low side is already off. The pulse holds until an edge samples `vout_hi` = 1; that edge turns `hs_on` off.
- R10: In hysteretic mode, `ls_on` drops combinationally in any cycle with `sw_pos` = 1. The low side then stays off until the next PFM pulse.
- R11: `hs_on` and `ls_on` are never 1 in the same cycle. Whenever one of them turns off, the other stays off for at least that cycle.
- R12: In soft-start and PWM, an edge that samples `pwm_hs` = 1 requests the high side and `pwm_hs` = 0 requests the low side. A request that reverses the gates yields one cycle with both off, then the requested gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one edge per switching cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Phase enable |
| uvlo_ok | input | 1 | Supply is above the undervoltage-lockout threshold |
| ss_done | input | 1 | Soft-start ramp has reached its final level |
| sw_pos | input | 1 | Switch-node polarity sample: 1 = positive (reverse inductor current) |
| pwm_hs | input | 1 | PWM comparator asks for the high side this cycle |
| vout_lo | input | 1 | Output is below the lower hysteretic threshold |
| vout_hi | input | 1 | Output is above the upper hysteretic threshold |
| vout_drop | input | 1 | Output is below the PWM-return threshold (load step) |
| hs_on | output | 1 | High-side gate request |
| ls_on | output | 1 | Low-side gate request |
| mode_hyst | output | 1 | 1 = hysteretic mode, 0 = PWM |
| pgood_en | output | 1 | Power-good comparators enabled |
| pwm_inhibit | output | 1 | Inhibits the PWM comparator and error amplifier |

## Verification
The bench breaks a positive run after five samples and then supplies exactly seven more positive samples. A filter that does not restart, or that fires at seven, would enter hysteretic mode too early. It holds the switch node positive through the whole of soft-start, which catches a design that arms its filter before the soft-start flag arrives. It raises the switch-node flag with the low side on and samples with no clock edge, so a registered-only diode cutoff shows up as a late drop. It also reverses the gate requests and checks the both-off gap cycle, the transition cycles on both mode changes and the single-edge exit on a load step. A design that overlaps the switches, skips the transition state or waits out the filter on a load step fails at those points.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_SOFTSTART = 3'd1,
        ST_PWM       = 3'd2,
        ST_TO_HYST   = 3'd3,
        ST_HYST      = 3'd4,
        ST_TO_PWM    = 3'd5
    } mode_state_e;

    localparam int unsigned NUM_RUN_FILTERS = 2;
    localparam int unsigned FILT_POSITIVE   = 0;
    localparam int unsigned FILT_NEGATIVE   = 1;

endpackage

// File: rtl/mode_run_filter.sv
// Counts consecutive matching samples; reports completion on the
// RUN_LEN-th match. Cleared whenever disabled or on a mismatch.
module mode_run_filter #(
    parameter int unsigned RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic match,
    output logic run_done
);
    localparam int unsigned CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || !match) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign run_done = enable && match && (cnt_q == LAST);

endmodule

// File: rtl/pfm_pulse_gen.sv
// Hysteretic-mode gate wishes: PFM pulse on the high side, low side as
// a synchronous rectifier that is blocked once the switch node turns positive.
module pfm_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic vout_lo,
    input  logic vout_hi,
    input  logic sw_pos,
    output logic want_hs,
    output logic want_ls
);
    logic pulse_q;
    logic block_q;

    always_comb begin
        want_hs = active && (pulse_q || vout_lo) && !vout_hi;
        want_ls = active && !want_hs && !block_q && !sw_pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            block_q <= 1'b0;
        end else begin
            pulse_q <= want_hs;
            if (!active || want_hs) begin
                block_q <= 1'b0;
            end else if (sw_pos) begin
                block_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/gate_interlock.sv
// Registered gate requests with break-before-make: a gate can only turn
// on if the opposite gate was off in the previous cycle.
module gate_interlock (
    input  logic clk,
    input  logic rst_n,
    input  logic force_off,
    input  logic want_hs,
    input  logic want_ls,
    input  logic diode_cut,
    output logic hs_on,
    output logic ls_on
);
    logic hs_q;
    logic ls_q;
    logic hs_d;
    logic ls_d;

    always_comb begin
        hs_d = !force_off && want_hs && !ls_q;
        ls_d = !force_off && want_ls && !want_hs && !hs_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            ls_q <= 1'b0;
        end else begin
            hs_q <= hs_d;
            ls_q <= ls_d;
        end
    end

    assign hs_on = hs_q;
    assign ls_on = ls_q && !diode_cut;

endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
    import buck_mode_pkg::*;
#(
    parameter int unsigned RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic uvlo_ok,
    input  logic ss_done,
    input  logic sw_pos,
    input  logic pwm_hs,
    input  logic vout_lo,
    input  logic vout_hi,
    input  logic vout_drop,
    output logic hs_on,
    output logic ls_on,
    output logic mode_hyst,
    output logic pgood_en,
    output logic pwm_inhibit
);
    mode_state_e state_q;
    mode_state_e state_d;

    logic run_ok;
    logic [NUM_RUN_FILTERS-1:0] flt_en;
    logic [NUM_RUN_FILTERS-1:0] flt_match;
    logic [NUM_RUN_FILTERS-1:0] flt_done;

    logic pfm_active;
    logic pfm_hs;
    logic pfm_ls;
    logic pwm_sel;
    logic force_off;
    logic want_hs;
    logic want_ls;
    logic diode_cut;

    assign run_ok = en && uvlo_ok;

    // Run filters: positive run armed in PWM, negative run armed in hysteretic.
    assign flt_en[FILT_POSITIVE]    = (state_q == ST_PWM);
    assign flt_match[FILT_POSITIVE] = sw_pos;
    assign flt_en[FILT_NEGATIVE]    = (state_q == ST_HYST);
    assign flt_match[FILT_NEGATIVE] = !sw_pos;

    for (genvar g = 0; g < NUM_RUN_FILTERS; g++) begin : g_filt
        mode_run_filter #(
            .RUN_LEN (RUN_LEN)
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (flt_en[g]),
            .match    (flt_match[g]),
            .run_done (flt_done[g])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!run_ok) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:       state_d = ST_SOFTSTART;
                ST_SOFTSTART: if (ss_done) state_d = ST_PWM;
                ST_PWM:       if (flt_done[FILT_POSITIVE]) state_d = ST_TO_HYST;
                ST_TO_HYST:   state_d = ST_HYST;
                ST_HYST:      if (vout_drop || flt_done[FILT_NEGATIVE]) state_d = ST_TO_PWM;
                ST_TO_PWM:    state_d = ST_PWM;
                default:      state_d = ST_OFF;
            endcase
        end
    end

    // Mode outputs decoded from the state
    always_comb begin
        mode_hyst   = 1'b0;
        pgood_en    = 1'b0;
        pwm_inhibit = 1'b0;
        unique case (state_q)
            ST_OFF, ST_SOFTSTART: begin
                pgood_en = 1'b0;
            end
            ST_PWM, ST_TO_HYST, ST_TO_PWM: begin
                pgood_en = 1'b1;
            end
            ST_HYST: begin
                pgood_en    = 1'b1;
                mode_hyst   = 1'b1;
                pwm_inhibit = 1'b1;
            end
            default: begin
                pgood_en = 1'b0;
            end
        endcase
    end

    // Gate wishes for the cycle that follows the coming edge
    assign pfm_active = (state_d == ST_HYST);
    assign pwm_sel    = (state_d == ST_SOFTSTART) || (state_d == ST_PWM);
    assign force_off  = (state_d == ST_OFF) || (state_d == ST_TO_HYST) ||
                        (state_d == ST_TO_PWM);
    assign want_hs    = pwm_sel ? pwm_hs  : pfm_hs;
    assign want_ls    = pwm_sel ? !pwm_hs : pfm_ls;
    assign diode_cut  = (state_q == ST_HYST) && sw_pos;

    pfm_pulse_gen u_pfm (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (pfm_active),
        .vout_lo (vout_lo),
        .vout_hi (vout_hi),
        .sw_pos  (sw_pos),
        .want_hs (pfm_hs),
        .want_ls (pfm_ls)
    );

    gate_interlock u_gates (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (force_off),
        .want_hs   (want_hs),
        .want_ls   (want_ls),
        .diode_cut (diode_cut),
        .hs_on     (hs_on),
        .ls_on     (ls_on)
    );

endmodule

// File: rtl/buck_mode_ctrl_chk.sv
module buck_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic uvlo_ok,
    input logic ss_done,
    input logic sw_pos,
    input logic vout_hi,
    input logic vout_drop,
    input logic hs_on,
    input logic ls_on,
    input logic mode_hyst,
    input logic pgood_en
);

    assert_off_when_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(en && uvlo_ok)) |-> (!hs_on && !ls_on && !mode_hyst && !pgood_en));

    assert_pgood_after_ss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood_en) |-> $past(ss_done));

    assert_hyst_after_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_hyst) |-> $past(sw_pos, 2));

    assert_drop_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hyst && vout_drop) |=> !mode_hyst);

    assert_enter_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_hyst) |-> $past(!hs_on && !ls_on));

    assert_exit_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_hyst) |-> (!hs_on && !ls_on));

    assert_pfm_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hyst && hs_on && vout_hi) |=> !hs_on);

    assert_diode_cut_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hyst && sw_pos) |-> !ls_on);

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    assert_hs_break_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_on) |-> !ls_on);

    assert_ls_break_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ls_on) |-> !hs_on);

endmodule

bind buck_mode_ctrl buck_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .uvlo_ok   (uvlo_ok),
    .ss_done   (ss_done),
    .sw_pos    (sw_pos),
    .vout_hi   (vout_hi),
    .vout_drop (vout_drop),
    .hs_on     (hs_on),
    .ls_on     (ls_on),
    .mode_hyst (mode_hyst),
    .pgood_en  (pgood_en)
);

// File: tb/tb_buck_mode_ctrl.sv
`timescale 1ns/1ps
module tb_buck_mode_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, uvlo_ok = 1'b0, ss_done = 1'b0, sw_pos = 1'b0;
    logic pwm_hs = 1'b0, vout_lo = 1'b0, vout_hi = 1'b0, vout_drop = 1'b0;
    logic hs_on, ls_on, mode_hyst, pgood_en, pwm_inhibit;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    buck_mode_ctrl #(.RUN_LEN(8)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .uvlo_ok(uvlo_ok),
        .ss_done(ss_done), .sw_pos(sw_pos), .pwm_hs(pwm_hs),
        .vout_lo(vout_lo), .vout_hi(vout_hi), .vout_drop(vout_drop),
        .hs_on(hs_on), .ls_on(ls_on), .mode_hyst(mode_hyst),
        .pgood_en(pgood_en), .pwm_inhibit(pwm_inhibit)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string req, input logic hs, input logic ls,
                           input logic md, input logic pg);
        chk(req, "hs_on", hs_on, hs);
        chk(req, "ls_on", ls_on, ls);
        chk(req, "mode_hyst", mode_hyst, md);
        chk(req, "pgood_en", pgood_en, pg);
        chk("R8", "pwm_inhibit", pwm_inhibit, md);
    endtask

    task automatic t_reset();
        #1;
        chk_all("R1", 0, 0, 0, 0);
        tick();
        rst_n = 1'b1;
        tick();
        chk_all("R1", 0, 0, 0, 0);
    endtask

    task automatic t_startup();
        en = 1'b1; pwm_hs = 1'b1;
        repeat (3) tick();
        chk_all("R1", 0, 0, 0, 0);          // supply not yet good
        uvlo_ok = 1'b1;
        tick();
        chk_all("R2", 1, 0, 0, 0);          // soft-start, PWM gating
        sw_pos = 1'b1;
        repeat (12) tick();
        chk_all("R3", 1, 0, 0, 0);          // held in PWM during soft-start
        sw_pos = 1'b0; ss_done = 1'b1;
        tick();
        chk_all("R3", 1, 0, 0, 1);          // power-good released
    endtask

    task automatic t_pwm_gating();
        pwm_hs = 1'b0;
        tick();
        chk_all("R12", 0, 0, 0, 1);         // break cycle
        tick();
        chk_all("R12", 0, 1, 0, 1);
        pwm_hs = 1'b1;
        tick();
        chk_all("R11", 0, 0, 0, 1);
        tick();
        chk_all("R12", 1, 0, 0, 1);
    endtask

    task automatic t_enter_hyst();
        sw_pos = 1'b1;
        repeat (5) tick();
        sw_pos = 1'b0;
        tick();
        sw_pos = 1'b1;
        repeat (7) tick();
        chk_all("R4", 1, 0, 0, 1);          // run restarted, only 7 so far
        tick();
        chk_all("R7", 0, 0, 0, 1);          // transition cycle
        sw_pos = 1'b0;
        tick();
        chk_all("R4", 0, 1, 1, 1);          // hysteretic, low side rectifying
    endtask

    task automatic t_diode_and_pfm();
        sw_pos = 1'b1;
        #1;
        chk("R10", "ls_on immediate cut", ls_on, 1'b0);
        tick();
        sw_pos = 1'b0;
        tick();
        chk_all("R10", 0, 0, 1, 1);         // stays blocked
        vout_lo = 1'b1;
        tick();
        chk_all("R9", 1, 0, 1, 1);          // PFM pulse starts
        vout_lo = 1'b0;
        repeat (2) tick();
        chk_all("R9", 1, 0, 1, 1);          // pulse held
        vout_hi = 1'b1;
        tick();
        chk_all("R9", 0, 0, 1, 1);          // pulse ends
        vout_hi = 1'b0;
        tick();
        chk_all("R11", 0, 1, 1, 1);         // low side after gap
        sw_pos = 1'b1;
        tick();
        chk_all("R10", 0, 0, 1, 1);
    endtask

    task automatic t_exit_neg();
        sw_pos = 1'b0; pwm_hs = 1'b1;
        repeat (7) tick();
        chk_all("R5", 0, 0, 1, 1);
        tick();
        chk_all("R5", 0, 0, 0, 1);          // back toward PWM
        chk_all("R7", 0, 0, 0, 1);
        tick();
        chk_all("R12", 1, 0, 0, 1);
    endtask

    task automatic t_drop();
        sw_pos = 1'b1;
        repeat (8) tick();
        chk_all("R7", 0, 0, 0, 1);
        tick();
        chk_all("R4", 0, 0, 1, 1);
        vout_drop = 1'b1;
        tick();
        chk_all("R6", 0, 0, 0, 1);          // immediate exit
        vout_drop = 1'b0; sw_pos = 1'b0;
        tick();
        chk_all("R6", 1, 0, 0, 1);
    endtask

    task automatic t_supply_loss();
        uvlo_ok = 1'b0;
        tick();
        chk_all("R1", 0, 0, 0, 0);
        uvlo_ok = 1'b1;
        tick();
        chk_all("R2", 1, 0, 0, 0);          // soft-start again
        tick();
        chk_all("R3", 1, 0, 0, 1);
        en = 1'b0;
        tick();
        chk_all("R1", 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_startup();
        t_pwm_gating();
        t_enter_hyst();
        t_diode_and_pfm();
        t_exit_neg();
        t_drop();
        t_supply_loss();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule